// File: doc/BRIEF.md
# Parallel-Load Serial Shifter with Hold-Gated Clock

This block turns a parallel word into a serial bit stream. While the mode pin `shift_nload_i` is low, every stage follows its parallel input bit directly, with no clock edge needed. This is a level-sensitive, asynchronous load. When the mode pin is high, the contents move one stage toward the output stage on each rising edge of an internal clock. The output stage holds the most significant word bit. The bit that leaves stage 0 free is refilled from `chain_i`, so several shifters can be daisy-chained.

The internal clock is the logical OR of `clk_i` and `hold_i`. Holding either pin high freezes the register. The other pin then acts as the clock, so either pin can serve as an active-low clock enable. The data path has no valid/ready handshake. A producer paces the output by choosing which effective clock edges it lets through. A consumer samples `tail_o` after each such edge.

Top module: `piso_hold_shifter`

## Requirements
- R1: The register has WIDTH stages (default 8), and `tail_o` is the last stage. After a word is loaded and released, successive shifts present word bits WIDTH-1, WIDTH-2, ... down to 0 on `tail_o`, in that order.
- R2: When `shift_nload_i` goes low, the register takes the word asynchronously. Bit WIDTH-1 of `word_i` appears on `tail_o` before any clock edge.
- R3: While `shift_nload_i` is low, a change on `word_i` reaches the stages at once. An effective clock edge during this time has no effect on `tail_o`.
- R4: While `shift_nload_i` is high, each rising edge of the effective clock moves every stage one place toward the output. Stage 0 takes the value `chain_i` had at that edge, so after WIDTH further shifts the chained bits appear on `tail_o` in the order they entered.
- R5: The effective clock is `clk_i` OR `hold_i`. A rising edge of `clk_i` while `hold_i` is high does not change the register.
- R6: With `clk_i` held low, each rising edge of `hold_i` shifts the register exactly once, the same as a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, ORed with `hold_i` to form the shift clock |
| hold_i | input | 1 | High freezes the register; its rising edges clock the register while `clk_i` is low |
| shift_nload_i | input | 1 | 0 = stages follow `word_i` asynchronously, 1 = shift on the effective clock |
| chain_i | input | 1 | Serial bit entering stage 0 on each shift |
| word_i | input | WIDTH | Parallel word; bit WIDTH-1 is the first bit sent out |
| tail_o | output | 1 | Content of the last stage |

## Verification
The bench changes `word_i` while the load is still held and expects the output to follow at once. A design that captured the word only on the falling mode edge would show the stale bit. It lets a clock edge through during a load and expects no change. It also drops `hold_i` at random across a long shift run, so a shifter that ignored the hold, or shifted on its release, would get ahead of the model. A final run stops `clk_i` and clocks with `hold_i` alone, which exposes a gate built as AND instead of OR, or one where the hold acts only as an enable.

// File: rtl/piso_pkg.sv
package piso_pkg;
  typedef enum logic {
    PM_LOAD  = 1'b0,
    PM_SHIFT = 1'b1
  } piso_mode_e;
endpackage

// File: rtl/piso_clk_or.sv
module piso_clk_or (
  input  logic clk_i,
  input  logic hold_i,
  output logic gclk_o
);
  // Either pin high holds the shift clock high; edges pass only from the other
  assign gclk_o = clk_i | hold_i;
endmodule

// File: rtl/piso_load_decode.sv
module piso_load_decode
  import piso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  piso_mode_e       mode_i,
  input  logic [WIDTH-1:0] word_i,
  output logic [WIDTH-1:0] set_o,
  output logic [WIDTH-1:0] clr_o
);
  // Per-stage asynchronous force, active only while loading
  always_comb begin
    if (mode_i == PM_LOAD) begin
      set_o = word_i;
      clr_o = ~word_i;
    end else begin
      set_o = '0;
      clr_o = '0;
    end
  end
endmodule

// File: rtl/piso_cell.sv
module piso_cell (
  input  logic gclk_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic din_i,
  output logic q_o
);
  always_ff @(posedge gclk_i or posedge set_i or posedge clr_i) begin
    if (set_i)      q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
    else            q_o <= din_i;
  end
endmodule

// File: rtl/piso_hold_shifter.sv
module piso_hold_shifter
  import piso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             hold_i,
  input  logic             shift_nload_i,
  input  logic             chain_i,
  input  logic [WIDTH-1:0] word_i,
  output logic             tail_o
);
  localparam int LAST = WIDTH - 1;

  logic             gclk;
  logic [WIDTH-1:0] set_v;
  logic [WIDTH-1:0] clr_v;
  logic [WIDTH-1:0] stage;
  logic [WIDTH-1:0] din_v;
  piso_mode_e       mode;

  assign mode = piso_mode_e'(shift_nload_i);

  piso_clk_or u_gate (
    .clk_i  (clk_i),
    .hold_i (hold_i),
    .gclk_o (gclk)
  );

  piso_load_decode #(.WIDTH(WIDTH)) u_dec (
    .mode_i (mode),
    .word_i (word_i),
    .set_o  (set_v),
    .clr_o  (clr_v)
  );

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_stage
      if (gi == 0) begin : g_head
        assign din_v[gi] = chain_i;
      end else begin : g_body
        assign din_v[gi] = stage[gi-1];
      end
      piso_cell u_cell (
        .gclk_i (gclk),
        .set_i  (set_v[gi]),
        .clr_i  (clr_v[gi]),
        .din_i  (din_v[gi]),
        .q_o    (stage[gi])
      );
    end
  endgenerate

  assign tail_o = stage[LAST];
endmodule

// File: rtl/piso_hold_checker.sv
module piso_hold_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             gclk_i,
  input logic             hold_i,
  input logic             shift_nload_i,
  input logic             chain_i,
  input logic [WIDTH-1:0] word_i,
  input logic [WIDTH-1:0] state_i,
  input logic             tail_i
);
  logic armed_g;
  logic armed_c;

  always_ff @(posedge gclk_i or negedge shift_nload_i) begin
    if (!shift_nload_i) armed_g <= 1'b0;
    else                armed_g <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge shift_nload_i) begin
    if (!shift_nload_i) armed_c <= 1'b0;
    else                armed_c <= 1'b1;
  end

  AST_SHIFT_STEP: assert property (@(posedge gclk_i) disable iff (!shift_nload_i)
    armed_g |-> (state_i == {$past(state_i[WIDTH-2:0]), $past(chain_i)})); // R4

  AST_HOLD_FREEZE: assert property (@(posedge clk_i) disable iff (!shift_nload_i)
    (armed_c && $past(hold_i)) |-> $stable(state_i)); // R5

  AST_LOAD_TRACK: assert property (@(posedge clk_i)
    !shift_nload_i |-> (state_i == word_i)); // R3

  AST_LOAD_MSB: assert property (@(posedge clk_i)
    !shift_nload_i |-> (tail_i == word_i[WIDTH-1])); // R2
endmodule

bind piso_hold_shifter piso_hold_checker #(.WIDTH(WIDTH)) u_chk (
  .clk_i         (clk_i),
  .gclk_i        (gclk),
  .hold_i        (hold_i),
  .shift_nload_i (shift_nload_i),
  .chain_i       (chain_i),
  .word_i        (word_i),
  .state_i       (stage),
  .tail_i        (tail_o)
);

// File: tb/sim_piso_hold_shifter.sv
module sim_piso_hold_shifter;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         run = 1'b1;
  logic         hold = 1'b1;
  logic         shift_nload = 1'b0;
  logic         chain = 1'b0;
  logic [W-1:0] word = 8'hA5;
  logic         tail;
  logic [W-1:0] model;
  int           checks = 0;
  int           errors = 0;
  bit           done = 1'b0;

  always #(CLK_PERIOD/2) clk = run ? ~clk : 1'b0;

  piso_hold_shifter #(.WIDTH(W)) u0 (
    .clk_i         (clk),
    .hold_i        (hold),
    .shift_nload_i (shift_nload),
    .chain_i       (chain),
    .word_i        (word),
    .tail_o        (tail)
  );

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: tail=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic load_now(logic [W-1:0] b);
    shift_nload = 1'b0;
    word = b;
    #1;
    model = b;
    chk("R2 async load shows top bit", tail, b[W-1]);
  endtask

  task automatic release_now();
    shift_nload = 1'b1;
    #1;
    chk("R1 release keeps top bit", tail, model[W-1]);
  endtask

  task automatic t_reset_state();
    #1;
    chk("R2 state at start follows word", tail, 1'b1);
  endtask

  task automatic t_load_tracking(logic [W-1:0] b);
    @(negedge clk);
    load_now(b);
    @(posedge clk); #2 hold = 1'b0;
    @(posedge clk); #2;
    chk("R3 clock edge during load ignored", tail, b[W-1]);
    hold = 1'b1;
    word = {~b[W-1], b[W-2:0]};
    #1 chk("R3 word change passes while loading", tail, ~b[W-1]);
    word = b;
    #1 chk("R3 word restored while loading", tail, b[W-1]);
    @(negedge clk);
    release_now();
  endtask

  task automatic t_shift(logic [W-1:0] b, int n, bit rand_hold, string tag);
    @(negedge clk);
    load_now(b);
    release_now();
    @(posedge clk); #2;
    for (int k = 0; k < n; k++) begin
      logic h_bit;
      logic c_bit;
      h_bit = rand_hold ? 1'($urandom_range(0, 1)) : 1'b0;
      c_bit = 1'($urandom_range(0, 1));
      hold = h_bit;
      chain = c_bit;
      @(posedge clk); #2;
      if (!h_bit) model = {model[W-2:0], c_bit};
      chk($sformatf("%s step %0d", tag, k), tail, model[W-1]);
    end
    hold = 1'b1;
  endtask

  task automatic t_hold_freeze(logic [W-1:0] b);
    @(negedge clk);
    load_now(b);
    release_now();
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #2;
      chain = ~chain;
      chk("R5 hold high blocks clock", tail, b[W-1]);
    end
  endtask

  task automatic t_hold_as_clock(logic [W-1:0] b);
    @(negedge clk);
    load_now(b);
    release_now();
    run = 1'b0;
    #(CLK_PERIOD * 2);
    for (int k = 0; k < W; k++) begin
      logic c_bit;
      c_bit = 1'($urandom_range(0, 1));
      chain = c_bit;
      hold = 1'b0;
      #3 hold = 1'b1;
      #2;
      model = {model[W-2:0], c_bit};
      chk($sformatf("R6 hold edge shifts %0d", k), tail, model[W-1]);
    end
    load_now(8'h3C);
    release_now();
    run = 1'b1;
  endtask

  initial begin
    t_reset_state();
    t_load_tracking(8'h5A);
    t_shift(8'hB1, W, 1'b0, "R1 bit order");
    t_shift(8'h6E, 2 * W, 1'b0, "R4 chain refill");
    t_shift(8'hC3, 3 * W, 1'b1, "R5 random hold");
    t_shift(8'h17, 3 * W, 1'b1, "R5 random hold b");
    t_hold_freeze(8'h80);
    t_hold_freeze(8'h7F);
    t_hold_as_clock(8'hD2);
    t_shift(8'h01, W, 1'b0, "R1 after restart");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, tail=%b expected completion", tail);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule